// File: doc/BRIEF.md
# Processor Supervisor Reset Sequencer

This block is the digital core of a processor supervisor. It runs on a system clock and uses a timebase tick that pulses once per microsecond. Analog comparators outside the block turn the supply state into digital flags: undervoltage, low-line and power-fail. The block also takes a raw manual-reset level and a watchdog activity line from the processor. From these it produces one reset output and two early-warning outputs.

The reset has three causes: a brownout, a qualified manual-reset press, and a watchdog that has gone silent. Whatever the cause, the reset is stretched by the same hold-off period, which starts counting once the cause has gone. A 4-bit selector picks the hold-off period and the watchdog period independently, one from each of two four-value grids. The reset polarity is chosen with a pin. If the watchdog line is fed from the reset output, the block runs as a slow free-running oscillator.

Timeouts are nominal microsecond values divided by `TIME_DIV`, with a minimum of one tick, so a simulation can scale them down. With the default `TIME_DIV` of 1000, the hold-off choices are 1, 28, 200 and 1600 ticks, and the watchdog choices are 6, 102, 1600 and 25600 ticks.

Top module: `supv_rst_seq`

## Requirements
- R1: While `uv_flag` is high, the internal reset is asserted at the next clock edge and stays asserted.
- R2: After `uv_flag` falls, the reset releases L ticks later, where L is the selected hold-off. If `uv_flag` rises again during the hold-off, the count restarts from zero.
- R3: `mr_n_raw` is active low and passes through a two-flop synchroniser. The reset asserts only after the synchronised level has been low for 38 consecutive ticks (a 25-tick qualification, one more tick, then a 12-tick delay). A shorter low pulse has no effect.
- R4: While the manual input stays low, the reset stays asserted. After the synchronised level returns high, the reset releases L ticks later.
- R5: Both rising and falling edges of `wdi` restart the watchdog count. The input passes through two synchroniser flops and one edge-detect flop.
- R6: With the reset released, if no `wdi` edge arrives for W ticks (the selected watchdog period), the reset asserts. It then releases after L ticks.
- R7: `tmo_sel[1:0]` selects the hold-off: 0, 1, 2 and 3 give 1400, 28000, 200000 and 1600000 µs. `tmo_sel[3:2]` selects the watchdog period: 0, 1, 2 and 3 give 6200, 102000, 1600000 and 25600000 µs. Each value is divided by `TIME_DIV`, with a minimum of 1 tick.
- R8: With `rst_active_high` at 1, `rst_out` is high while reset is asserted. With it at 0, `rst_out` is low while reset is asserted. A change of `rst_active_high` inverts `rst_out` in the same cycle.
- R9: `lowline_n` is the inverse of `lowline_flag` and `pfail_n` is the inverse of `pfail_flag`. Both are combinational, and neither depends on the reset state.
- R10: The watchdog count is held at zero while reset is asserted. After each release, the full W ticks pass before the watchdog can fire.
- R11: With `wdi` driven from `rst_out` and a tick on every clock, the reset is asserted for L cycles and released for W+3 cycles; the extra 3 cycles are the synchroniser latency.
- R12: After `rst_n` is released with the supply good, the reset is asserted and releases after exactly L ticks.
- R13: The hold-off, watchdog and manual-reset counters advance only on cycles where `tick_1us` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the logic |
| tick_1us | input | 1 | Timebase strobe, one cycle wide, once per microsecond |
| uv_flag | input | 1 | Synchronised undervoltage flag, high when the supply is low |
| lowline_flag | input | 1 | Low-line comparator flag |
| pfail_flag | input | 1 | Power-fail comparator flag |
| mr_n_raw | input | 1 | Raw manual-reset level, active low |
| wdi | input | 1 | Watchdog activity line |
| tmo_sel | input | 4 | Timeout selector: bits 1:0 select the hold-off, bits 3:2 select the watchdog period |
| rst_active_high | input | 1 | Reset polarity: 1 selects active high |
| rst_out | output | 1 | Reset output in the selected polarity |
| lowline_n | output | 1 | Low-line warning, active low |
| pfail_n | output | 1 | Power-fail warning, active low |

## Verification
Six selector codes each take a brownout pulse followed by a silent watchdog line. The measured hold-off and watchdog lengths show whether each field of the selector is decoded on its own. A glitch in the undervoltage flag during the hold-off shows whether the count restarts. A 37-tick manual press against a long press places the qualification boundary, and the release delay after the long press shows that the press is stretched. Toggling the watchdog line every four cycles tells an any-edge restart from a rising-only one. Feeding the watchdog line from the reset output checks the oscillator period, including the synchroniser latency.

// File: rtl/supv_rst_seq.sv
module supv_rst_seq #(
  parameter int unsigned TIME_DIV       = 1000,
  parameter int unsigned MR_QUAL_TICKS  = 25,
  parameter int unsigned MR_DELAY_TICKS = 12,
  parameter int unsigned CNT_W          = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1us,
  input  logic       uv_flag,
  input  logic       lowline_flag,
  input  logic       pfail_flag,
  input  logic       mr_n_raw,
  input  logic       wdi,
  input  logic [3:0] tmo_sel,
  input  logic       rst_active_high,
  output logic       rst_out,
  output logic       lowline_n,
  output logic       pfail_n
);
  function automatic int unsigned scl(input int unsigned us);
    int unsigned v;
    v = us / TIME_DIV;
    return (v == 0) ? 1 : v;
  endfunction

  localparam logic [CNT_W-1:0] HOLD0 = CNT_W'(scl(1400));
  localparam logic [CNT_W-1:0] HOLD1 = CNT_W'(scl(28000));
  localparam logic [CNT_W-1:0] HOLD2 = CNT_W'(scl(200000));
  localparam logic [CNT_W-1:0] HOLD3 = CNT_W'(scl(1600000));
  localparam logic [CNT_W-1:0] WD0   = CNT_W'(scl(6200));
  localparam logic [CNT_W-1:0] WD1   = CNT_W'(scl(102000));
  localparam logic [CNT_W-1:0] WD2   = CNT_W'(scl(1600000));
  localparam logic [CNT_W-1:0] WD3   = CNT_W'(scl(25600000));
  localparam int unsigned      MR_TOT = MR_QUAL_TICKS + 1 + MR_DELAY_TICKS;
  localparam int unsigned      MR_W   = $clog2(MR_TOT + 1);

  logic [CNT_W-1:0] hold_lim, wd_lim, hold_cnt, wd_cnt;
  logic [MR_W-1:0]  mr_cnt;
  logic [1:0]       mr_sync;
  logic [2:0]       wd_sync;
  logic             rst_act, mr_low, mr_hit, wd_edge, wd_fire;

  always_comb begin
    case (tmo_sel[1:0])
      2'd0:    hold_lim = HOLD0;
      2'd1:    hold_lim = HOLD1;
      2'd2:    hold_lim = HOLD2;
      default: hold_lim = HOLD3;
    endcase
    case (tmo_sel[3:2])
      2'd0:    wd_lim = WD0;
      2'd1:    wd_lim = WD1;
      2'd2:    wd_lim = WD2;
      default: wd_lim = WD3;
    endcase
  end

  assign mr_low  = ~mr_sync[1];
  assign mr_hit  = (mr_cnt == MR_W'(MR_TOT));
  assign wd_edge = wd_sync[2] ^ wd_sync[1];
  assign wd_fire = !rst_act && tick_1us && !wd_edge && (wd_cnt >= wd_lim - CNT_W'(1));

  assign rst_out   = rst_active_high ? rst_act : ~rst_act;
  assign lowline_n = ~lowline_flag;
  assign pfail_n   = ~pfail_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_sync <= 2'b11;
      wd_sync <= 3'b000;
    end else begin
      mr_sync <= {mr_sync[0], mr_n_raw};
      wd_sync <= {wd_sync[1:0], wdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mr_cnt <= '0;
    else if (!mr_low)                 mr_cnt <= '0;
    else if (tick_1us && !mr_hit)     mr_cnt <= mr_cnt + MR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_act  <= 1'b1;
      hold_cnt <= '0;
    end else if (uv_flag || mr_hit || wd_fire) begin
      rst_act  <= 1'b1;
      hold_cnt <= '0;
    end else if (rst_act && tick_1us) begin
      if (hold_cnt >= hold_lim - CNT_W'(1)) begin
        rst_act  <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              wd_cnt <= '0;
    else if (rst_act || wd_edge || wd_fire)  wd_cnt <= '0;
    else if (tick_1us)                       wd_cnt <= wd_cnt + CNT_W'(1);
  end
endmodule

// File: rtl/supv_rst_seq_chk.sv
module supv_rst_seq_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned MR_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             uv_flag,
  input logic             rst_act,
  input logic             mr_low,
  input logic             mr_hit,
  input logic [MR_W-1:0]  mr_cnt,
  input logic [CNT_W-1:0] wd_cnt
);
  p_uv_sets_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> rst_act);

  p_no_release_under_uv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_act) |-> !$past(uv_flag));

  p_mr_hit_asserts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mr_hit |=> rst_act);

  p_mr_idle_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_low |=> (mr_cnt == '0));

  p_wd_held_in_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> (wd_cnt == '0));
endmodule

bind supv_rst_seq supv_rst_seq_chk #(.CNT_W(CNT_W), .MR_W(MR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .rst_act(rst_act),
  .mr_low(mr_low), .mr_hit(mr_hit), .mr_cnt(mr_cnt), .wd_cnt(wd_cnt)
);

// File: tb/supv_rst_seq_tb_top.sv
module supv_rst_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n, tick_1us, uv_flag, lowline_flag, pfail_flag, mr_n_raw, wdi_drv;
  logic osc_mode, rst_active_high;
  logic [3:0] tmo_sel;
  logic rst_out, lowline_n, pfail_n, wdi;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign wdi = osc_mode ? rst_out : wdi_drv;

  supv_rst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .uv_flag(uv_flag),
    .lowline_flag(lowline_flag), .pfail_flag(pfail_flag), .mr_n_raw(mr_n_raw),
    .wdi(wdi), .tmo_sel(tmo_sel), .rst_active_high(rst_active_high),
    .rst_out(rst_out), .lowline_n(lowline_n), .pfail_n(pfail_n)
  );

  // {tmo_sel, hold ticks, watchdog ticks} at TIME_DIV = 1000
  localparam logic [35:0] VEC [6] = '{
    {4'h0, 16'd1,    16'd6},
    {4'h5, 16'd28,   16'd102},
    {4'hA, 16'd200,  16'd1600},
    {4'hF, 16'd1600, 16'd25600},
    {4'h3, 16'd1600, 16'd6},
    {4'hC, 16'd1,    16'd25600}
  };

  function automatic logic active();
    return rst_active_high ? rst_out : !rst_out;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_until(input logic want, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (active() != want && n < 40000);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int n, hits;
    rst_n = 0; tick_1us = 1; uv_flag = 0; lowline_flag = 0; pfail_flag = 0;
    mr_n_raw = 1; wdi_drv = 0; osc_mode = 0; rst_active_high = 0; tmo_sel = 4'hD;
    repeat (3) @(negedge clk);
    chk(active() == 1'b1, "R12 reset during power-on", active(), 1);
    chk(lowline_n && pfail_n, "R9 warnings idle", lowline_n, 1);
    rst_n = 1;
    count_until(1'b0, n);
    chk(n == 28, "R12 power-on hold", n, 28);

    lowline_flag = 1; #1;
    chk(lowline_n == 1'b0, "R9 lowline", lowline_n, 0);
    pfail_flag = 1; #1;
    chk(pfail_n == 1'b0 && active() == 1'b0, "R9 pfail independent of reset", pfail_n, 0);
    lowline_flag = 0; pfail_flag = 0; #1;
    chk(lowline_n && pfail_n, "R9 warnings cleared", pfail_n, 1);

    rst_active_high = 1; #1;
    chk(rst_out == 1'b0, "R8 active-high idle", rst_out, 0);
    @(negedge clk); uv_flag = 1;
    @(negedge clk);
    chk(rst_out == 1'b1, "R1 uv asserts reset (active high)", rst_out, 1);
    rst_active_high = 0; #1;
    chk(rst_out == 1'b0, "R8 active-low asserted", rst_out, 0);
    repeat (5) @(negedge clk);
    chk(active() == 1'b1, "R1 reset held while uv", active(), 1);
    uv_flag = 0;
    repeat (10) @(negedge clk);
    uv_flag = 1; @(negedge clk); uv_flag = 0;
    count_until(1'b0, n);
    chk(n == 28, "R2 hold restarts after uv glitch", n, 28);

    uv_flag = 1; @(negedge clk); uv_flag = 0; tick_1us = 0;
    repeat (60) @(negedge clk);
    chk(active() == 1'b1, "R13 no progress without tick", active(), 1);
    tick_1us = 1;
    count_until(1'b0, n);
    chk(n == 28, "R13 hold resumes with tick", n, 28);

    hits = 0;
    mr_n_raw = 0;
    for (int i = 0; i < 37; i++) begin @(negedge clk); hits += int'(active()); end
    mr_n_raw = 1;
    for (int i = 0; i < 45; i++) begin @(negedge clk); hits += int'(active()); end
    chk(hits == 0, "R3 37-tick press ignored", hits, 0);
    mr_n_raw = 0;
    repeat (40) @(negedge clk);
    chk(active() == 1'b0, "R3 not yet qualified", active(), 0);
    @(negedge clk);
    chk(active() == 1'b1, "R3 qualified press asserts", active(), 1);
    repeat (20) @(negedge clk);
    chk(active() == 1'b1, "R4 held while pressed", active(), 1);
    mr_n_raw = 1;
    count_until(1'b0, n);
    chk(n == 31, "R4 release after hold", n, 31);

    uv_flag = 1; tmo_sel = 4'h1; @(negedge clk); uv_flag = 0;
    count_until(1'b0, n);
    chk(n == 28, "R2 hold with new code", n, 28);
    hits = 0;
    for (int i = 0; i < 10; i++) begin
      wdi_drv = ~wdi_drv;
      repeat (4) begin @(negedge clk); hits += int'(active()); end
    end
    chk(hits == 0, "R5 both edges kick watchdog", hits, 0);
    wdi_drv = ~wdi_drv;
    count_until(1'b1, n);
    chk(n == 9, "R6 watchdog expiry", n, 9);
    count_until(1'b0, n);
    chk(n == 28, "R6 watchdog pulse length", n, 28);
    count_until(1'b1, n);
    chk(n == 6, "R10 full period after release", n, 6);
    count_until(1'b0, n);

    osc_mode = 1;
    count_until(1'b1, n);
    count_until(1'b0, n);
    for (int k = 0; k < 2; k++) begin
      count_until(1'b1, n);
      chk(n == 9, "R11 oscillator low-reset phase", n, 9);
      count_until(1'b0, n);
      chk(n == 28, "R11 oscillator reset phase", n, 28);
    end
    osc_mode = 0; wdi_drv = 0;

    for (int v = 0; v < 6; v++) begin
      uv_flag = 1; tmo_sel = VEC[v][35:32];
      @(negedge clk); uv_flag = 0;
      count_until(1'b0, n);
      chk(n == int'(VEC[v][31:16]), "R7 hold code", n, int'(VEC[v][31:16]));
      count_until(1'b1, n);
      chk(n == int'(VEC[v][15:0]), "R7 watchdog code", n, int'(VEC[v][15:0]));
      count_until(1'b0, n);
      chk(n == int'(VEC[v][31:16]), "R6 stretched watchdog reset", n, int'(VEC[v][31:16]));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule